// File: doc/BRIEF.md
# Flash Command Sequencer with Boot-Block Protection

This block is the command front end of a byte-wide NOR-style flash array with an 18-bit address space. It watches a synchronous bus (chip enable, output enable and write strobe, all active low) and turns multi-cycle unlock sequences into byte-program, sector-erase and chip-erase operations. It also handles a one-way boot-block lock and a product-identification read mode. Each accepted operation is timed by an internal counter. While that counter runs, `busy` is high. The result lands in the array when the count ends.

The address space is split into seven sectors: one boot block of 1/16 of the space, two parameter blocks of 1/32 each, one main block of 1/8 and three main blocks of 1/4. With `TOP_BOOT` at 0 the boot block sits at the bottom of the space. With `TOP_BOOT` at 1 the whole map is mirrored, so the boot block sits at the top. The cell array is a simulation model. It stores only the first 2^`WIN_W` bytes of each sector, and every byte outside those windows reads as erased.

Unlock cycles compare address bits [14:0] only. The prefix is data AAh at 5555h followed by data 55h at 2AAAh. The third write at 5555h selects the command: A0h program, 80h erase/lock family, 90h ID entry, F0h ID exit. An erase-family command then repeats the prefix, and its sixth write selects the action: 30h at any address erases that sector, 10h at 5555h erases the chip, and 40h at 5555h sets the lock.

Top module: `flash_cmd_seq`

## Requirements
- R1: `dout` is registered. One cycle after a clock edge that sees ce_n=0, oe_n=0 and we_n=1, it shows the byte at `addr`. After any other cycle it shows 00h. Erased bytes read FFh.
- R2: A write strobe is a run of cycles with ce_n=0, oe_n=1 and we_n=0. The address is taken in the strobe's first cycle and the data in its last cycle. A strobe is processed in the cycle after it ends. With oe_n=0 or ce_n=1 there is no strobe.
- R3: A program takes four writes: AAh@5555h, 55h@2AAAh, A0h@5555h, then the data at the target. The stored byte becomes old AND new.
- R4: Any unlock write whose address or data does not match the expected value returns the sequencer to idle. That write has no other effect.
- R5: A sector erase takes six writes and ends with 30h. It erases the sector holding the address taken at the start of the sixth strobe. The sector map mirrors when TOP_BOOT=1.
- R6: A chip erase takes six writes and ends with 10h@5555h. It erases every sector, except the boot block while protection is active.
- R7: While busy is high, every write strobe is ignored.
- R8: A lock-enable takes six writes and ends with 40h@5555h. It sets the lock, which only por_n clears. rst_n does not clear it.
- R9: While the lock is set and hv_ovr=0, a program or sector erase aimed at the boot block is refused: busy stays low and the data is unchanged.
- R10: With hv_ovr=1 the boot block can be programmed despite the lock. Protection returns once hv_ovr=0.
- R11: Writing 90h as the third cycle enters ID mode, and F0h leaves it. In ID mode, boot-block offsets 0, 1 and 2 read MFR_CODE, DEV_CODE and {7'b0, lock}. Other boot-block offsets read 00h.
- R12: busy rises in the cycle after an accepted final strobe. It stays high for PROG_CYC cycles for a program and ERASE_CYC cycles for an erase. The new contents are readable once it falls.
- R13: Bytes beyond the first 2^WIN_W of a sector read FFh. A program aimed there is still timed but changes nothing.
- R14: rst_n returns the sequencer to idle, leaves ID mode and abandons a running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset of the sequencer, mode and timer |
| por_n | input | 1 | Power-up initialisation: clears the lock and fills the array with FFh |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| hv_ovr | input | 1 | High-voltage override of the boot lock |
| dout | output | 8 | Registered read data |
| busy | output | 1 | Program or erase in progress |

## Verification
The bench builds the block with TOP_BOOT=1, so the boot block lies at 3C000h. This shows that the mirrored decode places the boot block at the top and that the lock bit comes back from 3C002h, not from address 2. PROG_CYC=5 and ERASE_CYC=24 are short enough for many operations to fit, yet long enough for a full four-write program sequence to arrive during a chip erase and be ignored. WIN_W=4 keeps every test address either inside a sector's stored window or, at 00100h, outside it.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int         ADDR_W    = 18,
  parameter bit         TOP_BOOT  = 1'b0,
  parameter int         WIN_W     = 4,
  parameter int         PROG_CYC  = 8,
  parameter int         ERASE_CYC = 64,
  parameter logic [7:0] MFR_CODE  = 8'hC3,
  parameter logic [7:0] DEV_CODE  = 8'h5E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              hv_ovr,
  output logic [7:0]        dout,
  output logic              busy
);
  localparam int NCELL = 8 << WIN_W;
  localparam int CW    = 3 + WIN_W;
  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC) + 1;
  localparam logic [ADDR_W-1:0] BOOT_BASE = TOP_BOOT ? {4'hF, {(ADDR_W-4){1'b0}}} : '0;
  localparam logic [14:0] KEY_A = 15'h5555;
  localparam logic [14:0] KEY_B = 15'h2AAA;

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PROG, S_E3, S_E4, S_E5} seq_e;

  function automatic logic [2:0] sec_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    m = TOP_BOOT ? ~a : a;
    if (m[ADDR_W-1:ADDR_W-2] != 2'b00) return 3'd3 + {1'b0, m[ADDR_W-1:ADDR_W-2]};
    else if (m[ADDR_W-3])              return 3'd3;
    else if (!m[ADDR_W-4])             return 3'd0;
    else if (!m[ADDR_W-5])             return 3'd1;
    else                               return 3'd2;
  endfunction

  function automatic logic in_win(input logic [ADDR_W-1:0] a, input logic [2:0] s);
    int sb;
    logic [ADDR_W-1:0] msk;
    case (s)
      3'd0:       sb = ADDR_W - 4;
      3'd1, 3'd2: sb = ADDR_W - 5;
      3'd3:       sb = ADDR_W - 3;
      default:    sb = ADDR_W - 2;
    endcase
    msk = ((ADDR_W'(1) << sb) - ADDR_W'(1)) & ~(ADDR_W'(1 << WIN_W) - ADDR_W'(1));
    return (a & msk) == '0;
  endfunction

  seq_e              st, st_nxt;
  logic              wr_prev, wr_act, wr_beg, wr_end;
  logic [ADDR_W-1:0] cap_a, boff;
  logic [7:0]        cap_d, rd_val;
  logic              lock_q, id_mode, prot, fire, key_a, key_b;
  logic [7:0]        cells [NCELL];
  logic [CNT_W-1:0]  op_cnt;
  logic              op_prog, op_hit;
  logic [7:0]        op_mask;
  logic [CW-1:0]     op_idx;
  logic [7:0]        op_data;
  logic [2:0]        w_sec, rd_sec;
  logic              go_prog, go_ser, go_chip, go_lock, go_id_on, go_id_off;
  logic              start_prog, start_ser;

  assign wr_act = !ce_n && oe_n && !we_n;
  assign wr_beg = wr_act && !wr_prev;
  assign wr_end = wr_prev && !wr_act;
  assign key_a  = cap_a[14:0] == KEY_A;
  assign key_b  = cap_a[14:0] == KEY_B;
  assign prot   = lock_q && !hv_ovr;
  assign w_sec  = sec_of(cap_a);
  assign fire   = busy && (op_cnt == '0);
  assign start_prog = go_prog && !(prot && w_sec == 3'd0);
  assign start_ser  = go_ser  && !(prot && w_sec == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev <= 1'b0;
      cap_a   <= '0;
      cap_d   <= '0;
    end else begin
      wr_prev <= wr_act;
      if (wr_beg) cap_a <= addr;
      if (wr_act) cap_d <= din;
    end
  end

  always_comb begin
    st_nxt    = st;
    go_prog   = 1'b0;
    go_ser    = 1'b0;
    go_chip   = 1'b0;
    go_lock   = 1'b0;
    go_id_on  = 1'b0;
    go_id_off = 1'b0;
    if (wr_end && !busy) begin
      st_nxt = S_IDLE;
      case (st)
        S_IDLE: if (key_a && cap_d == 8'hAA) st_nxt = S_U1;
        S_U1:   if (key_b && cap_d == 8'h55) st_nxt = S_U2;
        S_U2:
          if (key_a) begin
            case (cap_d)
              8'hA0:   st_nxt = S_PROG;
              8'h80:   st_nxt = S_E3;
              8'h90:   go_id_on = 1'b1;
              8'hF0:   go_id_off = 1'b1;
              default: st_nxt = S_IDLE;
            endcase
          end
        S_PROG: go_prog = 1'b1;
        S_E3:   if (key_a && cap_d == 8'hAA) st_nxt = S_E4;
        S_E4:   if (key_b && cap_d == 8'h55) st_nxt = S_E5;
        S_E5:
          if (cap_d == 8'h30)               go_ser  = 1'b1;
          else if (key_a && cap_d == 8'h10) go_chip = 1'b1;
          else if (key_a && cap_d == 8'h40) go_lock = 1'b1;
        default: st_nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      id_mode <= 1'b0;
    end else begin
      st <= st_nxt;
      if (go_id_on)       id_mode <= 1'b1;
      else if (go_id_off) id_mode <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       lock_q <= 1'b0;
    else if (go_lock) lock_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      op_cnt  <= '0;
      op_prog <= 1'b0;
      op_hit  <= 1'b0;
      op_mask <= '0;
      op_idx  <= '0;
      op_data <= '0;
    end else if (fire) begin
      busy <= 1'b0;
    end else if (busy) begin
      op_cnt <= op_cnt - CNT_W'(1);
    end else if (start_prog) begin
      busy    <= 1'b1;
      op_prog <= 1'b1;
      op_hit  <= in_win(cap_a, w_sec);
      op_mask <= 8'(1) << w_sec;
      op_idx  <= {w_sec, cap_a[WIN_W-1:0]};
      op_data <= cap_d;
      op_cnt  <= CNT_W'(PROG_CYC - 1);
    end else if (start_ser || go_chip) begin
      busy    <= 1'b1;
      op_prog <= 1'b0;
      op_mask <= go_chip ? {1'b0, 6'h3F, !prot} : (8'(1) << w_sec);
      op_cnt  <= CNT_W'(ERASE_CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < NCELL; i++) cells[i] <= 8'hFF;
    end else if (fire) begin
      if (op_prog) begin
        if (op_hit) cells[op_idx] <= cells[op_idx] & op_data;
      end else begin
        for (int i = 0; i < NCELL; i++)
          if (op_mask[i >> WIN_W]) cells[i] <= 8'hFF;
      end
    end
  end

  assign rd_sec = sec_of(addr);
  assign boff   = addr - BOOT_BASE;

  always_comb begin
    rd_val = in_win(addr, rd_sec) ? cells[{rd_sec, addr[WIN_W-1:0]}] : 8'hFF;
    if (id_mode && rd_sec == 3'd0) begin
      if (boff == ADDR_W'(0))      rd_val = MFR_CODE;
      else if (boff == ADDR_W'(1)) rd_val = DEV_CODE;
      else if (boff == ADDR_W'(2)) rd_val = {7'b0, lock_q};
      else                         rd_val = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= 8'h00;
    else        dout <= (!ce_n && !oe_n && we_n) ? rd_val : 8'h00;
  end
endmodule

module flash_cmd_seq_chk #(
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       por_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       hv_ovr,
  input logic       busy,
  input logic       lock_q,
  input logic [7:0] dout,
  input logic [7:0] op_mask,
  input logic [2:0] seq_st
);
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |=> lock_q);

  a_r7_busy_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> seq_st == 3'd0);

  a_r9_boot_guard: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ($rose(busy) && $past(lock_q && !hv_ovr)) |-> !op_mask[0]);

  a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |=> dout == 8'h00);

  generate
    if (PROG_CYC > 1 && ERASE_CYC > 1) begin : g_hold
      a_r12_busy_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
    end
  endgenerate
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .hv_ovr(hv_ovr), .busy(busy), .lock_q(lock_q), .dout(dout), .op_mask(op_mask),
  .seq_st(st)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int PC = 5;
  localparam int EC = 24;
  localparam logic [7:0] MFR = 8'hC3;
  localparam logic [7:0] DEV = 8'h5E;

  logic clk = 1'b0, rst_n = 1'b0, por_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hv_ovr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic busy;

  int checks = 0, errors = 0;
  logic armed = 1'b0;
  logic [7:0] q_exp[$];
  string q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .TOP_BOOT(1'b1), .WIN_W(4), .PROG_CYC(PC),
    .ERASE_CYC(EC), .MFR_CODE(MFR), .DEV_CODE(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .hv_ovr(hv_ovr), .dout(dout), .busy(busy));

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    if (armed && q_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(dout, e, t);
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk);
    armed = 1'b1;
    @(negedge clk);
    armed = 1'b0; oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic wr_shift(input logic [AW-1:0] a0, input logic [AW-1:0] a1, input logic [7:0] d);
    @(negedge clk);
    addr = a0; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    addr = a1;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic cmd3(input logic [7:0] c);
    wr(18'h05555, 8'hAA);
    wr(18'h02AAA, 8'h55);
    wr(18'h05555, c);
  endtask

  task automatic cmd6(input logic [AW-1:0] a, input logic [7:0] c);
    cmd3(8'h80);
    wr(18'h05555, 8'hAA);
    wr(18'h02AAA, 8'h55);
    wr(a, c);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    cmd3(8'hA0);
    wr(a, d);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    check(dout, 8'h00, "R1 reset dout");
    check(busy, 0, "R12 reset busy");
    rd(18'h00000, 8'hFF, "R1 erased read");

    prog(18'h00005, 8'h3C);
    check(busy, 1, "R12 busy after program");
    wait_idle(n);
    check(n, PC, "R12 program length");
    rd(18'h00005, 8'h3C, "R3 program");
    prog(18'h00005, 8'hF5);
    wait_idle(n);
    rd(18'h00005, 8'h34, "R3 AND rule");

    wr(18'h05555, 8'hAA);
    wr(18'h01234, 8'h55);
    wr(18'h05555, 8'hA0);
    wr(18'h00006, 8'h00);
    check(busy, 0, "R4 abort no op");
    rd(18'h00006, 8'hFF, "R4 abort");

    @(negedge clk); oe_n = 1'b0;
    wr(18'h05555, 8'hAA);
    @(negedge clk); oe_n = 1'b1;
    wr(18'h02AAA, 8'h55);
    wr(18'h05555, 8'hA0);
    wr(18'h00008, 8'h00);
    rd(18'h00008, 8'hFF, "R2 oe inhibit");

    prog(18'h10003, 8'h11);
    wait_idle(n);
    rd(18'h10003, 8'h11, "R3 program m3");
    cmd3(8'h80);
    wr(18'h05555, 8'hAA);
    wr(18'h02AAA, 8'h55);
    wr_shift(18'h10000, 18'h00000, 8'h30);
    check(busy, 1, "R5 erase started");
    wait_idle(n);
    check(n, EC, "R12 erase length");
    rd(18'h10003, 8'hFF, "R5 sector erased");
    rd(18'h00005, 8'h34, "R2 start address kept");

    prog(18'h00100, 8'h00);
    check(busy, 1, "R13 timed outside window");
    wait_idle(n);
    rd(18'h00100, 8'hFF, "R13 outside window");

    prog(18'h38001, 8'h0F);
    wait_idle(n);
    prog(18'h3C001, 8'hA5);
    wait_idle(n);
    rd(18'h3C001, 8'hA5, "R10 boot writable unlocked");
    cmd6(18'h05555, 8'h10);
    prog(18'h20001, 8'h00);
    wait_idle(n);
    rd(18'h20001, 8'hFF, "R7 write ignored while busy");
    rd(18'h38001, 8'hFF, "R6 chip erase param");
    rd(18'h3C001, 8'hFF, "R6 chip erase boot unlocked");

    cmd3(8'h90);
    rd(18'h3C002, 8'h00, "R11 lock bit clear");
    rd(18'h3C000, MFR, "R11 mfr code");
    rd(18'h3C001, DEV, "R11 dev code");
    cmd3(8'hF0);
    rd(18'h3C002, 8'hFF, "R11 exit");

    prog(18'h3C001, 8'h5A);
    wait_idle(n);
    cmd6(18'h05555, 8'h40);
    cmd3(8'h90);
    rd(18'h3C002, 8'h01, "R8 lock set");
    cmd3(8'hF0);

    prog(18'h3C003, 8'h00);
    check(busy, 0, "R9 program refused");
    rd(18'h3C003, 8'hFF, "R9 boot program blocked");
    cmd6(18'h3C000, 8'h30);
    check(busy, 0, "R9 erase refused");
    rd(18'h3C001, 8'h5A, "R9 boot erase blocked");
    prog(18'h00007, 8'h00);
    wait_idle(n);
    cmd6(18'h05555, 8'h10);
    wait_idle(n);
    rd(18'h00007, 8'hFF, "R6 chip erase main");
    rd(18'h3C001, 8'h5A, "R6 boot kept when locked");

    hv_ovr = 1'b1;
    prog(18'h3C003, 8'h12);
    wait_idle(n);
    rd(18'h3C003, 8'h12, "R10 override program");
    hv_ovr = 1'b0;
    prog(18'h3C004, 8'h00);
    rd(18'h3C004, 8'hFF, "R10 protection restored");

    wr(18'h05555, 8'hAA);
    wr(18'h02AAA, 8'h55);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    wr(18'h05555, 8'hA0);
    wr(18'h00009, 8'h00);
    rd(18'h00009, 8'hFF, "R14 reset clears sequence");
    cmd3(8'h90);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(18'h3C002, 8'hFF, "R14 reset leaves ID mode");
    cmd3(8'h90);
    rd(18'h3C002, 8'h01, "R8 lock survives rst_n");
    cmd3(8'hF0);

    repeat (4) @(negedge clk);
    report();
  end
endmodule